// File: doc/BRIEF.md
# Configurable Sequential Logic Macrocell

This block is a single cell of a small sequential programmable logic device. Two sum-of-products planes read the same input vector. Each plane has four product terms. Each term sees four inputs plus the cell's own stored bit, fed back as a fifth literal. The planes drive one storage bit, which acts either as a D flip-flop or as a JK flip-flop. In D mode the bit loads plane A. In JK mode plane A is J and plane B is K.

A separate option chooses what reaches the cell output. The output can come straight from the OR of plane A, with no clock latency. It can also come from the stored bit, in which case it changes only on clock edges.

The configuration arrives on parallel ports. The cell captures it on every clock edge at which the synchronous active-low reset is asserted, and holds it otherwise.

Top module: `seq_macrocell`

## Requirements
- R1: Each literal of a product term has a 2-bit connection code: 00 forces the term to 0, 01 uses the signal true, 10 uses it complemented, and 11 leaves the literal out. Literal j of term t sits at bits [(t*5+j)*2 +: 2] of a plane vector. Literals 0..3 are in_vec[0..3] and literal 4 is the stored bit.
- R2: A plane's sum is the OR of its four product terms.
- R3: The configuration ports are captured on each rising edge where rst_n is low.
- R4: A rising edge with rst_n low clears the stored bit to 0, in either mode and whatever the inputs.
- R5: In D mode (cfg_jk_mode=0) the stored bit loads the plane A sum on each rising edge.
- R6: In JK mode, J=0 and K=0 leaves the stored bit unchanged.
- R7: In JK mode, J=0 and K=1 clears the bit, and J=1 and K=0 sets it.
- R8: In JK mode, J=1 and K=1 inverts the stored bit.
- R9: With cfg_registered=0, cell_out equals the plane A sum in the same cycle, with no clock latency.
- R10: With cfg_registered=1, cell_out equals the stored bit and changes only at clock edges.
- R11: Terms that use the feedback literal evaluate against the current stored bit.
- R12: Changes on the configuration ports while rst_n is high have no effect on cell behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; also the configuration load strobe |
| in_vec | input | 4 | Shared inputs to both planes |
| cfg_plane_a | input | 40 | Connection codes for plane A (D or J) |
| cfg_plane_b | input | 40 | Connection codes for plane B (K) |
| cfg_jk_mode | input | 1 | 1 selects JK behaviour, 0 selects D |
| cfg_registered | input | 1 | 1 routes the stored bit to the output, 0 routes the plane A sum |
| cell_out | output | 1 | Cell output |

## Verification
Reset and a set request can fall on the same edge. The bench provokes this by holding J at 1 with a constant-true term in JK mode and dropping rst_n mid-run. The stored bit must read 0 afterwards, so reset wins.

The toggle code and the feedback literal also meet in one cycle, because each next value depends on the bit the edge is about to overwrite. The bench drives repeated 11 codes and runs a plane built from the complemented feedback term. A behavioural reference model is compared against cell_out every cycle.

// File: rtl/mc_pkg.sv
// Shared definitions for the sequential macrocell.
// Assumes two connection bits per literal, with codes as defined below.
package mc_pkg;

    typedef enum logic [1:0] {
        LINK_OPEN = 2'b00,   // both rails connected: term forced low
        LINK_TRUE = 2'b01,   // true rail
        LINK_COMP = 2'b10,   // complement rail
        LINK_SKIP = 2'b11    // literal removed from the term
    } link_code_e;

    // Value one literal contributes to its product term.
    function automatic logic link_eval(input logic [1:0] code, input logic sig);
        case (code)
            LINK_OPEN: return 1'b0;
            LINK_TRUE: return sig;
            LINK_COMP: return ~sig;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/mc_sop_plane.sv
// One sum-of-products plane: N_TERMS products over N_IN inputs plus one
// feedback literal, ORed into a single sum.
// Assumes codes are packed term-major, with the feedback literal last.
module mc_sop_plane #(
    parameter int N_IN    = 4,
    parameter int N_TERMS = 4
) (
    input  logic [N_TERMS*(N_IN+1)*2-1:0] links,
    input  logic [N_IN-1:0]               in_vec,
    input  logic                          fb,
    output logic                          sum
);
    import mc_pkg::*;

    localparam int N_LIT = N_IN + 1;

    logic [N_TERMS-1:0][N_LIT-1:0] lit_v;
    logic [N_TERMS-1:0]            prod;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        for (genvar j = 0; j < N_LIT; j++) begin : g_lit
            if (j < N_IN) begin : g_pin
                // input literal
                assign lit_v[t][j] = link_eval(links[(t*N_LIT+j)*2 +: 2], in_vec[j]);
            end else begin : g_fb
                // feedback literal
                assign lit_v[t][j] = link_eval(links[(t*N_LIT+j)*2 +: 2], fb);
            end
        end
        // AND of all literals of the term
        assign prod[t] = &lit_v[t];
    end

    // Fixed OR of the products
    assign sum = |prod;

endmodule

// File: rtl/mc_cfg_hold.sv
// Configuration holding registers: load while reset is asserted, hold otherwise.
// Assumes configuration is only meaningful once one reset edge has occurred.
module mc_cfg_hold #(
    parameter int FUSE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUSE_W-1:0] plane_a_in,
    input  logic [FUSE_W-1:0] plane_b_in,
    input  logic              jk_in,
    input  logic              reg_in,
    output logic [FUSE_W-1:0] plane_a_q,
    output logic [FUSE_W-1:0] plane_b_q,
    output logic              jk_q,
    output logic              reg_q
);
    // Capture the configuration on reset edges
    always_ff @(posedge clk) begin : cfg_load
        if (!rst_n) begin
            plane_a_q <= plane_a_in;
            plane_b_q <= plane_b_in;
            jk_q      <= jk_in;
            reg_q     <= reg_in;
        end
    end

    // R12
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(plane_a_q) && $stable(plane_b_q) && $stable(jk_q) && $stable(reg_q)));

endmodule

// File: rtl/mc_store.sv
// Storage bit that behaves as a D or a JK flip-flop.
// Assumes d_j carries D in D mode and J in JK mode; k is ignored in D mode.
module mc_store (
    input  logic clk,
    input  logic rst_n,
    input  logic jk_mode,
    input  logic d_j,
    input  logic k,
    output logic q
);
    // Next-state update for both flip-flop kinds
    always_ff @(posedge clk) begin : state_update
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!jk_mode) begin
            q <= d_j;
        end else begin
            case ({d_j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end

    // R4
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (q == 1'b0));
    // R5
    d_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!jk_mode) |=> (q == $past(d_j)));
    // R6
    jk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jk_mode && !d_j && !k) |=> $stable(q));
    // R7
    jk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jk_mode && d_j && !k) |=> q);
    // R7
    jk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jk_mode && !d_j && k) |=> !q);
    // R8
    jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jk_mode && d_j && k) |=> (q != $past(q)));

endmodule

// File: rtl/seq_macrocell.sv
// Top of one macrocell: two SOP planes, a D/JK storage bit and an output select.
// Assumes configuration is loaded by holding rst_n low for at least one edge.
module seq_macrocell #(
    parameter int N_IN    = 4,
    parameter int N_TERMS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0]               in_vec,
    input  logic [N_TERMS*(N_IN+1)*2-1:0] cfg_plane_a,
    input  logic [N_TERMS*(N_IN+1)*2-1:0] cfg_plane_b,
    input  logic                          cfg_jk_mode,
    input  logic                          cfg_registered,
    output logic                          cell_out
);
    localparam int FUSE_W = N_TERMS * (N_IN + 1) * 2;

    logic [FUSE_W-1:0] links_a, links_b;
    logic              jk_q, reg_q;
    logic              sum_a, sum_b, q;

    mc_cfg_hold #(.FUSE_W(FUSE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .plane_a_in(cfg_plane_a), .plane_b_in(cfg_plane_b),
        .jk_in(cfg_jk_mode), .reg_in(cfg_registered),
        .plane_a_q(links_a), .plane_b_q(links_b),
        .jk_q(jk_q), .reg_q(reg_q)
    );

    mc_sop_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_plane_a (
        .links(links_a), .in_vec(in_vec), .fb(q), .sum(sum_a)
    );

    mc_sop_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_plane_b (
        .links(links_b), .in_vec(in_vec), .fb(q), .sum(sum_b)
    );

    mc_store u_store (
        .clk(clk), .rst_n(rst_n), .jk_mode(jk_q),
        .d_j(sum_a), .k(sum_b), .q(q)
    );

    // Output select between the OR gate and the stored bit
    always_comb begin : out_select
        cell_out = reg_q ? q : sum_a;
    end

    // R10
    reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q && !jk_q && $past(rst_n)) |-> (cell_out == $past(sum_a)));

endmodule

// File: tb/tb_seq_macrocell.sv
// Cycle-by-cycle reference model comparison for the macrocell.
module tb_seq_macrocell;

    localparam int FW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    in_vec = '0;
    logic [FW-1:0] cfg_a = '0, cfg_b = '0;
    logic          cfg_jk = 1'b0, cfg_reg = 1'b0;
    logic          cell_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [FW-1:0] m_a, m_b;
    logic          m_jk, m_reg, m_q;
    bit            m_valid = 0;

    always #5 clk = ~clk;

    seq_macrocell dut (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
        .cfg_plane_a(cfg_a), .cfg_plane_b(cfg_b),
        .cfg_jk_mode(cfg_jk), .cfg_registered(cfg_reg),
        .cell_out(cell_out)
    );

    function automatic logic [FW-1:0] link(input logic [FW-1:0] v, input int t,
                                           input int j, input logic [1:0] c);
        logic [FW-1:0] r = v;
        r[(t*5+j)*2 +: 2] = c;
        return r;
    endfunction

    function automatic logic [FW-1:0] term_skip_all(input logic [FW-1:0] v, input int t);
        logic [FW-1:0] r = v;
        for (int j = 0; j < 5; j++) r = link(r, t, j, 2'b11);
        return r;
    endfunction

    function automatic logic eval(input logic [FW-1:0] p, input logic [3:0] iv, input logic fq);
        logic s = 0;
        for (int t = 0; t < 4; t++) begin
            logic pr = 1;
            for (int j = 0; j < 5; j++) begin
                logic x = (j < 4) ? iv[j] : fq;
                logic [1:0] c = p[(t*5+j)*2 +: 2];
                if (c == 2'b00) pr = 0;
                else if (c == 2'b01 && !x) pr = 0;
                else if (c == 2'b10 && x) pr = 0;
            end
            if (pr) s = 1;
        end
        return s;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: cell_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive, compare before the edge, advance the model at the edge.
    task automatic step(input logic [3:0] iv, input logic rv, input string req);
        logic ja, kb;
        in_vec = iv;
        rst_n  = rv;
        #1;
        if (m_valid) chk(req, cell_out, m_reg ? m_q : eval(m_a, iv, m_q));
        ja = m_valid ? eval(m_a, iv, m_q) : 1'b0;
        kb = m_valid ? eval(m_b, iv, m_q) : 1'b0;
        @(posedge clk);
        if (!rv) begin
            m_a = cfg_a; m_b = cfg_b; m_jk = cfg_jk; m_reg = cfg_reg;
            m_q = 0; m_valid = 1;
        end else if (!m_jk) m_q = ja;
        else if (ja && kb) m_q = ~m_q;
        else if (ja) m_q = 1;
        else if (kb) m_q = 0;
        @(negedge clk);
    endtask

    task automatic load(input logic [FW-1:0] a, input logic [FW-1:0] b,
                        input logic jk, input logic rg);
        cfg_a = a; cfg_b = b; cfg_jk = jk; cfg_reg = rg;
        step(4'h0, 1'b0, "R3");
        step(4'h0, 1'b0, "R4");
        step(4'h0, 1'b1, "R4");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stimulus
        logic [FW-1:0] pa, pb;
        @(negedge clk);

        // D registered: a = in0&in1 | ~in2&in3   (R1, R2, R5, R10)
        pa = '0;
        pa = term_skip_all(pa, 0); pa = link(pa, 0, 0, 2'b01); pa = link(pa, 0, 1, 2'b01);
        pa = term_skip_all(pa, 1); pa = link(pa, 1, 2, 2'b10); pa = link(pa, 1, 3, 2'b01);
        load(pa, '0, 1'b0, 1'b1);
        for (int i = 0; i < 32; i++) step(4'(i * 7), 1'b1, "R5");

        // Same function, combinational output (R9, R2)
        load(pa, '0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, "R9");

        // Literal codes: term0 has an open literal, term1 = ~in2 only (R1)
        pa = '0;
        pa = term_skip_all(pa, 0); pa = link(pa, 0, 0, 2'b01); pa = link(pa, 0, 1, 2'b00);
        pa = term_skip_all(pa, 1); pa = link(pa, 1, 2, 2'b10);
        load(pa, '0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, "R1");

        // JK registered: J = in0, K = in1 (R6, R7, R8)
        pa = term_skip_all('0, 0); pa = link(pa, 0, 0, 2'b01);
        pb = term_skip_all('0, 0); pb = link(pb, 0, 1, 2'b01);
        load(pa, pb, 1'b1, 1'b1);
        step(4'h1, 1'b1, "R7");
        step(4'h0, 1'b1, "R6");
        step(4'h0, 1'b1, "R6");
        step(4'h2, 1'b1, "R7");
        step(4'h3, 1'b1, "R8");
        step(4'h3, 1'b1, "R8");
        step(4'h3, 1'b1, "R8");
        step(4'h0, 1'b1, "R6");
        for (int i = 0; i < 24; i++) step(4'((i * 5) % 4), 1'b1, "R8");

        // Configuration change while running is ignored (R12)
        cfg_a = '0; cfg_b = '1; cfg_jk = 1'b0; cfg_reg = 1'b0;
        step(4'h1, 1'b1, "R12");
        step(4'h3, 1'b1, "R12");
        step(4'h3, 1'b1, "R12");
        step(4'h0, 1'b1, "R12");
        step(4'h1, 1'b1, "R12");

        // Feedback: a = ~q&in3 | q&~in3, combinational view (R11)
        pa = term_skip_all('0, 0); pa = link(pa, 0, 4, 2'b10); pa = link(pa, 0, 3, 2'b01);
        pa = term_skip_all(pa, 1); pa = link(pa, 1, 4, 2'b01); pa = link(pa, 1, 3, 2'b10);
        load(pa, '0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, "R11");

        // Toggle driven by feedback only: a = ~q, registered (R11)
        pa = term_skip_all('0, 0); pa = link(pa, 0, 4, 2'b10);
        load(pa, '0, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) step(4'h0, 1'b1, "R11");

        // Reset against a set request in the same cycle (R4)
        pa = term_skip_all('0, 0);
        load(pa, '0, 1'b1, 1'b1);
        step(4'h0, 1'b1, "R7");
        step(4'h0, 1'b1, "R7");
        step(4'h0, 1'b0, "R4");
        step(4'h0, 1'b1, "R4");
        step(4'h0, 1'b1, "R7");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule